// File: doc/BRIEF.md
# SD Host Data Buffer

This block sits between a processor register port and the data side of an SD card controller. It holds sixteen 16-bit halfwords. Software moves data in bursts of one full buffer. For a card read, it waits for the full flag and then takes exactly sixteen halfwords. For a card write, it waits for the empty flag and then loads sixteen halfwords. The card side is an abstract byte stream with a valid/ready handshake in each direction. Each halfword goes out, or is built, low byte first: the first byte is bits 7:0 and the second byte is bits 15:8.

Software sets the block size in bytes. Writing the block count starts a transfer, with the direction sampled from `xfer_dir_wr` in that same cycle. A small controller counts halfwords and blocks as they cross the card side, and raises the done flag once the last halfword of the last block has crossed.

The controller has three states:
- `ST_IDLE`: no transfer is running.
- `ST_XFER`: card-side traffic is allowed.
- `ST_DONE`: the programmed blocks have all crossed.

Its transitions are:
- `ST_IDLE`/`ST_DONE` → `ST_XFER` on a block-count write with a nonzero value.
- `ST_XFER` → `ST_DONE` when the final halfword of the final block crosses the card side.
- Any state → `ST_IDLE` on a block-count write of zero.
- Any state → `ST_XFER` on a nonzero block-count write, which restarts the counts.

Top module: `sdf_data_buf`

## Requirements
- R1: After reset, `status` reads 16'h0040 when `card_tx_ready` is low (only the empty flag, bit 6, is set), `card_rx_ready` is 0 and `card_tx_valid` is 0.
- R2: The buffer holds 16 halfwords. Status bit 7 is 1 exactly when 16 are held, and bit 6 is 1 exactly when none are held.
- R3: Halfwords leave in the order they entered. A one-cycle `host_rd` pulse puts the popped halfword on `host_rdata` after that clock edge.
- R4: A `host_rd` pulse on an empty buffer leaves `host_rdata` at the last popped value and leaves the buffer empty.
- R5: In write direction, a `host_wr` when 16 halfwords are held is dropped and sets status bits 5:0 to 6'h08. The code stays until the next block-count write.
- R6: `card_rx_ready` is 1 only in `ST_XFER`, in read direction, while the buffer is not full.
- R7: In write direction during `ST_XFER`, `card_tx_valid` is 1 while the buffer is non-empty. The halfwords leave in buffer order.
- R8: Halfwords per block equal the block size in bytes divided by two. Status bit 12 (done) becomes 1 in the cycle after the last card-side halfword of the last block, is 0 before that, and holds until a block-count write.
- R9: A block-count write clears the counters, done and the error code. A count of zero returns to `ST_IDLE`.
- R10: Status bit 8 follows `card_tx_ready`. Bits 15:13 and 11:9 read 0.
- R11: On the card side, the first byte of each halfword is bits 7:0 and the second byte is bits 15:8, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Processor halfword write strobe |
| host_wdata | input | 16 | Processor write halfword |
| host_rd | input | 1 | Processor halfword read strobe |
| host_rdata | output | 16 | Last popped halfword |
| bsz_we | input | 1 | Block-size write strobe |
| bsz_wdata | input | 12 | Block size in bytes |
| bcnt_we | input | 1 | Block-count write strobe; starts or stops a transfer |
| bcnt_wdata | input | 16 | Number of blocks |
| xfer_dir_wr | input | 1 | Direction sampled with the block count: 1 = card write |
| status | output | 16 | Done bit 12, card ready bit 8, full bit 7, empty bit 6, error bits 5:0 |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_byte | input | 8 | Byte from card |
| card_rx_ready | output | 1 | Buffer accepts a card byte |
| card_tx_valid | output | 1 | Byte for the card available |
| card_tx_byte | output | 8 | Byte to card |
| card_tx_ready | input | 1 | Card accepts a byte |

## Verification
The bench fills the buffer from the card side and drains it through the processor port, using several block sizes and block counts. A design with a wrong wrap point or wrong byte lanes would return swapped bytes or stale halfwords. A done flag that fires per block or per chunk, rather than after the last block, is caught by checking done before the final chunk. Writing into a full buffer must not corrupt the data and must leave a sticky error code. Reading an empty buffer must not step the pointer, since a design that underflows would return the wrong halfword first in the next transfer. A zero block count must park the card side, and must clear done and the error.

// File: rtl/sdf_pkg.sv
`timescale 1ns/1ps
package sdf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } xfer_st_e;

    localparam logic [5:0] ERR_OVF = 6'h08;
endpackage

// File: rtl/sdf_fifo.sv
`timescale 1ns/1ps
module sdf_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [DW-1:0]                 push_data,
    input  logic                          pop,
    output logic [DW-1:0]                 peek,
    output logic [DW-1:0]                 head_q,
    output logic                          full,
    output logic                          empty,
    output logic [$clog2(DEPTH+1)-1:0]    level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] lvl_q;
    logic          push_ok, pop_ok;

    assign full    = (lvl_q == CW'(DEPTH));
    assign empty   = (lvl_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign level   = lvl_q;
    assign peek    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl_q  <= '0;
            head_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
                head_q <= mem[rd_ptr];
            end
            if (push_ok && !pop_ok)      lvl_q <= lvl_q + CW'(1);
            else if (pop_ok && !push_ok) lvl_q <= lvl_q - CW'(1);
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= CW'(DEPTH)); // R2
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> ($stable(head_q) && empty)); // R4
    AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full); // R5
endmodule

// File: rtl/sdf_xfer_ctrl.sv
`timescale 1ns/1ps
module sdf_xfer_ctrl
    import sdf_pkg::*;
#(
    parameter int BCNT_W = 16,
    parameter int BSZ_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bcnt_we,
    input  logic [BCNT_W-1:0] bcnt_wdata,
    input  logic [BSZ_W-1:0]  bsz_bytes,
    input  logic              beat,
    output xfer_st_e          state,
    output logic              done
);
    localparam int HW_W = BSZ_W - 1;

    xfer_st_e          state_q, state_d;
    logic [HW_W-1:0]   hw_lim, hw_cnt;
    logic [BCNT_W-1:0] blk_cnt, blk_total;
    logic              last_hw, last_blk;

    assign hw_lim   = (bsz_bytes[BSZ_W-1:1] == '0) ? HW_W'(1) : bsz_bytes[BSZ_W-1:1];
    assign last_hw  = (hw_cnt == hw_lim - HW_W'(1));
    assign last_blk = (blk_cnt == blk_total - BCNT_W'(1));

    always_comb begin
        state_d = state_q;
        if (bcnt_we) begin
            state_d = (bcnt_wdata == '0) ? ST_IDLE : ST_XFER;
        end else begin
            unique case (state_q)
                ST_IDLE: begin end
                ST_XFER: if (beat && last_hw && last_blk) state_d = ST_DONE;
                ST_DONE: begin end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_cnt    <= '0;
            blk_cnt   <= '0;
            blk_total <= '0;
        end else if (bcnt_we) begin
            hw_cnt    <= '0;
            blk_cnt   <= '0;
            blk_total <= bcnt_wdata;
        end else if (beat && state_q == ST_XFER) begin
            if (last_hw) begin
                hw_cnt  <= '0;
                blk_cnt <= blk_cnt + BCNT_W'(1);
            end else begin
                hw_cnt  <= hw_cnt + HW_W'(1);
            end
        end
    end

    always_comb begin
        state = state_q;
        done  = (state_q == ST_DONE);
    end

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !bcnt_we) |=> (state_q == ST_DONE)); // R8
    AST_BCNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt_we |=> (hw_cnt == '0 && blk_cnt == '0 && !done)); // R9
endmodule

// File: rtl/sdf_data_buf.sv
`timescale 1ns/1ps
module sdf_data_buf
    import sdf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BCNT_W = 16,
    parameter int BSZ_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [15:0]       host_wdata,
    input  logic              host_rd,
    output logic [15:0]       host_rdata,
    input  logic              bsz_we,
    input  logic [BSZ_W-1:0]  bsz_wdata,
    input  logic              bcnt_we,
    input  logic [BCNT_W-1:0] bcnt_wdata,
    input  logic              xfer_dir_wr,
    output logic [15:0]       status,
    input  logic              card_rx_valid,
    input  logic [7:0]        card_rx_byte,
    output logic              card_rx_ready,
    output logic              card_tx_valid,
    output logic [7:0]        card_tx_byte,
    input  logic              card_tx_ready
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [BSZ_W-1:0] BSZ_RST = BSZ_W'(512);

    xfer_st_e         xst;
    logic             done, dir_q, rx_ph, tx_ph, in_xfer;
    logic [7:0]       rx_lo;
    logic [5:0]       err_q;
    logic [BSZ_W-1:0] bsz_q;
    logic             rx_take, tx_take, rx_push, tx_pop, beat;
    logic             f_push, f_pop, f_full, f_empty;
    logic [15:0]      f_wdata, f_peek;
    logic [CW-1:0]    f_level;

    assign in_xfer       = (xst == ST_XFER);
    assign card_rx_ready = in_xfer && !dir_q && !f_full;
    assign card_tx_valid = in_xfer && dir_q && !f_empty;
    assign card_tx_byte  = tx_ph ? f_peek[15:8] : f_peek[7:0];
    assign rx_take       = card_rx_valid && card_rx_ready;
    assign tx_take       = card_tx_valid && card_tx_ready;
    assign rx_push       = rx_take && rx_ph;
    assign tx_pop        = tx_take && tx_ph;
    assign beat          = rx_push || tx_pop;

    assign f_push  = dir_q ? host_wr : rx_push;
    assign f_wdata = dir_q ? host_wdata : {card_rx_byte, rx_lo};
    assign f_pop   = dir_q ? tx_pop : host_rd;

    sdf_fifo #(.DW(16), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(f_push), .push_data(f_wdata), .pop(f_pop),
        .peek(f_peek), .head_q(host_rdata),
        .full(f_full), .empty(f_empty), .level(f_level)
    );

    sdf_xfer_ctrl #(.BCNT_W(BCNT_W), .BSZ_W(BSZ_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bcnt_we(bcnt_we), .bcnt_wdata(bcnt_wdata),
        .bsz_bytes(bsz_q), .beat(beat),
        .state(xst), .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bsz_q <= BSZ_RST;
            dir_q <= 1'b0;
            err_q <= '0;
            rx_ph <= 1'b0;
            tx_ph <= 1'b0;
            rx_lo <= '0;
        end else begin
            if (bsz_we) bsz_q <= bsz_wdata;
            if (bcnt_we) begin
                dir_q <= xfer_dir_wr;
                err_q <= '0;
                rx_ph <= 1'b0;
                tx_ph <= 1'b0;
            end else begin
                if (host_wr && dir_q && f_full) err_q <= ERR_OVF;
                if (rx_take) begin
                    rx_ph <= !rx_ph;
                    if (!rx_ph) rx_lo <= card_rx_byte;
                end
                if (tx_take) tx_ph <= !tx_ph;
            end
        end
    end

    assign status = {3'b000, done, 3'b000, card_tx_ready, f_full, f_empty, err_q};

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q == ERR_OVF && !bcnt_we) |=> (err_q == ERR_OVF)); // R5
    AST_DONE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (xst == ST_DONE) |-> !beat); // R8
    AST_TX_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        card_tx_valid |-> (f_level != '0)); // R7
endmodule

// File: tb/sdf_data_buf_tb.sv
`timescale 1ns/1ps
module sdf_data_buf_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, host_wr, host_rd, bsz_we, bcnt_we, xfer_dir_wr;
    logic [15:0] host_wdata, host_rdata, bcnt_wdata, status;
    logic [11:0] bsz_wdata;
    logic        card_rx_valid, card_rx_ready, card_tx_valid, card_tx_ready;
    logic [7:0]  card_rx_byte, card_tx_byte;

    int checks = 0;
    int errors = 0;
    logic [15:0] last_pop;

    sdf_data_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .bsz_we(bsz_we), .bsz_wdata(bsz_wdata),
        .bcnt_we(bcnt_we), .bcnt_wdata(bcnt_wdata),
        .xfer_dir_wr(xfer_dir_wr), .status(status),
        .card_rx_valid(card_rx_valid), .card_rx_byte(card_rx_byte),
        .card_rx_ready(card_rx_ready),
        .card_tx_valid(card_tx_valid), .card_tx_byte(card_tx_byte),
        .card_tx_ready(card_tx_ready)
    );

    // {block size bytes[15:0], blocks[7:0], first byte value[7:0]}
    localparam logic [31:0] RD_VEC [4] = '{
        {16'd32, 8'd1, 8'h10},
        {16'd64, 8'd2, 8'h40},
        {16'd32, 8'd3, 8'hA0},
        {16'd96, 8'd1, 8'h05}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_bsz(input logic [11:0] v);
        bsz_we = 1'b1; bsz_wdata = v; step(); bsz_we = 1'b0;
    endtask

    task automatic wr_bcnt(input logic [15:0] v, input logic dir);
        bcnt_we = 1'b1; bcnt_wdata = v; xfer_dir_wr = dir; step(); bcnt_we = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b);
        card_rx_valid = 1'b1; card_rx_byte = b; step(); card_rx_valid = 1'b0;
    endtask

    task automatic pop(output logic [15:0] d);
        host_rd = 1'b1; step(); host_rd = 1'b0; d = host_rdata;
    endtask

    task automatic hwrite(input logic [15:0] v);
        host_wr = 1'b1; host_wdata = v; step(); host_wr = 1'b0;
    endtask

    task automatic run_read(input int bsz, input int nblk, input logic [7:0] seed);
        int chunks;
        int k;
        logic [15:0] d;
        chunks = (bsz / 2) * nblk / 16;
        k = 0;
        wr_bsz(12'(bsz));
        wr_bcnt(16'(nblk), 1'b0);
        for (int c = 0; c < chunks; c++) begin
            for (int j = 0; j < 32; j++) feed(seed + 8'(k + j));
            chk("R2 full after 16 halfwords", {31'd0, status[7]}, 32'd1);
            chk("R6 rx_ready low when full", {31'd0, card_rx_ready}, 32'd0);
            chk("R8 done only after last block", {31'd0, status[12]},
                (c == chunks - 1) ? 32'd1 : 32'd0);
            for (int i = 0; i < 16; i++) begin
                pop(d);
                chk("R3 R11 read order and byte lanes", {16'd0, d},
                    {16'd0, seed + 8'(k + 2*i + 1), seed + 8'(k + 2*i)});
            end
            k += 32;
        end
        chk("R2 empty after drain", {31'd0, status[6]}, 32'd1);
        last_pop = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        rst_n = 1'b0; host_wr = 0; host_rd = 0; bsz_we = 0; bcnt_we = 0;
        xfer_dir_wr = 0; host_wdata = '0; bsz_wdata = '0; bcnt_wdata = '0;
        card_rx_valid = 0; card_rx_byte = '0; card_tx_ready = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        chk("R1 reset status", {16'd0, status}, 32'h0040);
        chk("R1 reset rx_ready", {31'd0, card_rx_ready}, 32'd0);
        chk("R1 reset tx_valid", {31'd0, card_tx_valid}, 32'd0);

        for (int v = 0; v < 4; v++)
            run_read(int'(RD_VEC[v][31:16]), int'(RD_VEC[v][15:8]), RD_VEC[v][7:0]);

        // R4: popping an empty buffer keeps the last value
        pop(d);
        chk("R4 empty pop keeps last value", {16'd0, d}, {16'd0, last_pop});
        chk("R4 still empty", {31'd0, status[6]}, 32'd1);
        run_read(32, 1, 8'h77);

        // Write direction
        wr_bsz(12'd32);
        wr_bcnt(16'd1, 1'b1);
        chk("R6 rx_ready low in write direction", {31'd0, card_rx_ready}, 32'd0);
        for (int i = 0; i < 16; i++)
            hwrite({8'h30 + 8'(2*i + 1), 8'h30 + 8'(2*i)});
        chk("R2 full after 16 writes", {31'd0, status[7]}, 32'd1);
        hwrite(16'hDEAD);
        chk("R5 overflow code", {26'd0, status[5:0]}, 32'h08);
        chk("R5 still full", {31'd0, status[7]}, 32'd1);
        chk("R10 ready bit low", {31'd0, status[8]}, 32'd0);
        chk("R10 reserved bits zero", {16'd0, status & 16'hEE00}, 32'd0);
        card_tx_ready = 1'b1;
        #1;
        chk("R10 ready bit follows card", {31'd0, status[8]}, 32'd1);
        for (int j = 0; j < 32; j++) begin
            chk("R7 tx_valid while data held", {31'd0, card_tx_valid}, 32'd1);
            chk("R7 R11 tx byte order", {24'd0, card_tx_byte}, {24'd0, 8'h30 + 8'(j)});
            step();
        end
        chk("R8 done after write block", {31'd0, status[12]}, 32'd1);
        chk("R7 tx_valid low when empty", {31'd0, card_tx_valid}, 32'd0);
        chk("R5 overflow code sticky", {26'd0, status[5:0]}, 32'h08);
        card_tx_ready = 1'b0;

        // R9: zero block count clears and parks
        wr_bcnt(16'd0, 1'b0);
        chk("R9 status cleared", {16'd0, status}, 32'h0040);
        card_rx_valid = 1'b1;
        #1;
        chk("R9 R6 idle blocks card input", {31'd0, card_rx_ready}, 32'd0);
        card_rx_valid = 1'b0;
        step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule